// File: doc/BRIEF.md
# Synchronous Serial Shift Port with Collision Detection

The block is an 8-bit synchronous serial port that sits on a small processor bus. It holds one data register, which is used both to transmit and to receive. It also holds a status register with two flags: one for transfer complete and one for data collision. In master mode, a bus write to the data register starts a transfer. The block then generates the serial clock from the system clock through a fixed divider. It drives data out MSB first, changing the output on each falling serial-clock edge, and it samples the input on each rising edge. In slave mode the serial clock comes from outside. It passes through a two-flop synchronizer, and the block acts on the detected edges.

The two flags follow a two-step handshake. Software reads the status register, then reads or writes the data register. That second access clears the completion flag. It clears the collision flag only if the completion flag was set when the status read was made. The window for a collision opens at the first falling serial-clock edge and closes at the final rising edge. Any data-register access inside that window sets the collision flag, and a set event wins over a clear in the same cycle. The read data on the bus follows the address combinationally. Side effects happen only on a strobe.

Top module: `sio_port`

## Requirements
- R1: After a synchronous active-low reset, both flags are zero and the serial clock output is high. The status register at address 0x0B reads with bits 5..0 zero.
- R2: In master mode, a write to address 0x0C while the port is idle starts a transfer. The first falling SCK edge comes DIV/2 clocks after the write edge. Exactly 8 low pulses follow, with period DIV, and SCK stays high between transfers.
- R3: Data leaves MSB first on the serial output, which changes on falling edges. The serial input is sampled on rising edges. After the transfer, the data register at 0x0C holds the 8 received bits, first bit in bit 7.
- R4: The completion flag (status bit 7) sets on the eighth rising SCK edge, which comes 8*DIV clocks after the write edge in master mode.
- R5: The completion flag stays set until a status read is followed by a data-register access. A data-register access made before the status read does not clear it.
- R6: If the completion flag is cleared while a transfer is running, the final rising edge of that transfer sets it again.
- R7: Any read or write of 0x0C after the first falling SCK edge and up to the final rising edge sets the collision flag (status bit 6).
- R8: The collision flag clears only when a data-register access follows a status read made while the completion flag was set. A status read made while the completion flag is clear can still clear the completion flag, but not the collision flag.
- R9: If the clearing access lands after a new transfer has reached its first falling edge, the collision flag is set again.
- R10: A write to 0x0C during a master transfer does not restart the clock. The completion flag still sets 8*DIV clocks after the original write.
- R11: Reset does not change the contents of the data register.
- R12: In slave mode, a data write does not start SCK. The external clock, after synchronization, shifts data out and in exactly as in R3, and its eighth rising edge sets the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Bus byte address |
| rd | input | 1 | Read strobe, one clock per access |
| wr | input | 1 | Write strobe, one clock per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register, combinational |
| master | input | 1 | 1 selects master mode, 0 selects slave mode |
| sck_in | input | 1 | External serial clock for slave mode |
| sck_out | output | 1 | Generated serial clock; held high in slave mode |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |

## Verification
Flag updates and the start of a transfer are registered, so they show up one clock after the strobe edge. The first falling SCK edge is due DIV/2 clocks after the write edge, and the completion flag is due 8*DIV clocks after it. In slave mode, each external edge takes three clocks to act, because of the synchronizer and the edge-detect stage. A behavioural model in the bench counts clock edges from the start write and predicts SCK and both flags. The bench compares the model against the design 5 ns after every rising edge. The directed checks use timed peeks placed at the exact clocks on either side of the completion edge. Register reads are combinational, so each peek samples 1 ns after the address changes, with no strobe.

// File: rtl/sio_pkg.sv
// Package: shared types for the serial shift port.
// Assumes: one clock domain; serial-clock edges arrive as single-cycle pulses.
package sio_pkg;
    // One-cycle pulses marking serial-clock edges in the system clock domain.
    typedef struct packed {
        logic fall;
        logic rise;
    } sck_evt_t;
endpackage

// File: rtl/sio_mclk.sv
// Module: master serial-clock generator.
// Divides the system clock by 2*HALF while a transfer runs; SCK idles high.
// Assumes: start is ignored while running; stop arrives on the final rising edge.
module sio_mclk #(
    parameter int HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               stop,
    output logic               sck,
    output logic               run,
    output sio_pkg::sck_evt_t  evt
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    // Half-period boundary: SCK toggles on this cycle's closing edge.
    assign tick     = run && (cnt == CW'(HALF - 1));
    assign evt.fall = tick && sck;
    assign evt.rise = tick && !sck;

    // Run control, half-period counter and SCK level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
            sck <= 1'b1;
        end else if (!run) begin
            cnt <= '0;
            sck <= 1'b1;
            if (start) run <= 1'b1;
        end else begin
            cnt <= tick ? '0 : cnt + CW'(1);
            if (tick) sck <= ~sck;
            if (stop) run <= 1'b0;
        end
    end
endmodule

// File: rtl/sio_sync.sv
// Module: external serial-clock synchronizer and edge detector.
// Two flops resynchronize sck_in; a third flop gives the edge detection.
// Assumes: external SCK half period longer than three system clocks; idle high.
module sio_sync (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_in,
    output sio_pkg::sck_evt_t  evt
);
    localparam int STAGES = 3;

    logic [STAGES-1:0] sh;

    // Shift the raw clock through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], sck_in};
    end

    assign evt.fall = sh[STAGES-1] && !sh[STAGES-2];
    assign evt.rise = !sh[STAGES-1] && sh[STAGES-2];
endmodule

// File: rtl/sio_shift.sv
// Module: single-buffered data register, shifter and bit counter.
// Output changes on falls, input is taken on rises, MSB first.
// Assumes: a bus load wins over a shift in the same cycle; data has no reset.
module sio_shift #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sio_pkg::sck_evt_t  evt,
    input  logic               load,
    input  logic [WIDTH-1:0]   wdata,
    input  logic               sdi,
    output logic [WIDTH-1:0]   data,
    output logic               sdo,
    output logic               late,
    output logic               done
);
    localparam int BW = (WIDTH > 2) ? $clog2(WIDTH) : 1;

    logic [BW-1:0] bitcnt;

    // The final rising edge of a transfer.
    assign done = evt.rise && late && (bitcnt == BW'(WIDTH - 1));

    // Transfer window, bit count and serial output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            late   <= 1'b0;
            bitcnt <= '0;
            sdo    <= 1'b0;
        end else begin
            if (evt.fall) begin
                late <= 1'b1;
                sdo  <= data[WIDTH-1];
            end
            if (evt.rise && late) begin
                bitcnt <= done ? '0 : bitcnt + BW'(1);
                if (done) late <= 1'b0;
            end
        end
    end

    // Data register: bus load or serial shift; kept through reset.
    always_ff @(posedge clk) begin
        if (load)                  data <= wdata;
        else if (evt.rise && late) data <= {data[WIDTH-2:0], sdi};
    end
endmodule

// File: rtl/sio_flags.sv
// Module: completion and collision flags with the two-step clear handshake.
// Assumes: stat_rd and data_acc are never high in the same cycle.
module sio_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic data_acc,
    input  logic done,
    input  logic collide,
    output logic spif,
    output logic dcol,
    output logic arm,
    output logic arm_sp
);
    // Track the handshake and update both flags, set winning over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spif   <= 1'b0;
            dcol   <= 1'b0;
            arm    <= 1'b0;
            arm_sp <= 1'b0;
        end else begin
            if (stat_rd) begin
                arm    <= 1'b1;
                arm_sp <= spif;
            end else if (data_acc) begin
                arm    <= 1'b0;
                arm_sp <= 1'b0;
            end
            spif <= done    | (spif & ~(data_acc & arm));
            dcol <= collide | (dcol & ~(data_acc & arm_sp));
        end
    end
endmodule

// File: rtl/sio_port.sv
// Module: serial shift port top.
// Decodes the bus, picks the clock source by mode and flags illegal accesses.
// Assumes: DIV even and at least 2; WIDTH at least 3; one strobe per access.
module sio_port #(
    parameter int          WIDTH     = 8,
    parameter int          ADDR_W    = 8,
    parameter int          DIV       = 4,
    parameter int unsigned STAT_ADDR = 'h0B,
    parameter int unsigned DATA_ADDR = 'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata,
    input  logic              master,
    input  logic              sck_in,
    output logic              sck_out,
    input  logic              sdi,
    output logic              sdo
);
    import sio_pkg::*;

    localparam int HALF = DIV / 2;

    logic             stat_sel, data_sel, stat_rd, data_acc, load;
    logic             m_sck, m_run, late, done, collide;
    logic             spif, dcol, arm, arm_sp;
    logic [WIDTH-1:0] data;
    sck_evt_t         m_evt, s_evt, evt;

    // Bus decode.
    assign stat_sel = (addr == ADDR_W'(STAT_ADDR));
    assign data_sel = (addr == ADDR_W'(DATA_ADDR));
    assign stat_rd  = rd & stat_sel;
    assign data_acc = (rd | wr) & data_sel;
    assign load     = wr & data_sel;
    assign collide  = data_acc & late;

    sio_mclk #(.HALF(HALF)) u_mclk (
        .clk(clk), .rst_n(rst_n), .start(load & master), .stop(done),
        .sck(m_sck), .run(m_run), .evt(m_evt)
    );

    sio_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .evt(s_evt)
    );

    // Clock source by mode.
    assign evt     = master ? m_evt : s_evt;
    assign sck_out = master ? m_sck : 1'b1;

    sio_shift #(.WIDTH(WIDTH)) u_shift (
        .clk(clk), .rst_n(rst_n), .evt(evt), .load(load), .wdata(wdata),
        .sdi(sdi), .data(data), .sdo(sdo), .late(late), .done(done)
    );

    sio_flags u_flags (
        .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_acc(data_acc),
        .done(done), .collide(collide), .spif(spif), .dcol(dcol),
        .arm(arm), .arm_sp(arm_sp)
    );

    // Read mux: status flags in the top two bits, data register, else zero.
    always_comb begin
        if (stat_sel)      rdata = {spif, dcol, {(WIDTH-2){1'b0}}};
        else if (data_sel) rdata = data;
        else               rdata = '0;
    end
endmodule

// File: rtl/sio_port_chk.sv
// Module: property checker for the serial shift port, bound to the top.
// Assumes: samples on the rising system-clock edge; reset is active low.
module sio_port_chk (
    input logic clk,
    input logic rst_n,
    input logic master,
    input logic sck_out,
    input logic run,
    input logic done,
    input logic late,
    input logic data_acc,
    input logic spif,
    input logic dcol,
    input logic arm,
    input logic arm_sp
);
    a_r2_idle_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !run) |-> sck_out);

    a_r4_spif_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> spif);

    a_r5_spif_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (spif && !(data_acc && arm)) |=> spif);

    a_r7_dcol_on_late_access: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && late) |=> dcol);

    a_r8_dcol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dcol && !(data_acc && arm_sp)) |=> dcol);

    a_r10_write_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run && data_acc && !done) |=> run);
endmodule

bind sio_port sio_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .master(master), .sck_out(sck_out),
    .run(m_run), .done(done), .late(late), .data_acc(data_acc),
    .spif(spif), .dcol(dcol), .arm(arm), .arm_sp(arm_sp)
);

// File: tb/test_sio_port.sv
module test_sio_port;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;
    localparam int XE   = 16 * HALF;
    localparam int HP   = 8;
    localparam logic [7:0] SSR = 8'h0B;
    localparam logic [7:0] SDR = 8'h0C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = SSR;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       master = 1'b1;
    logic       sck_in = 1'b1;
    logic       sck_out;
    logic       sdi = 1'b0;
    logic       sdo;

    int   checks = 0, errors = 0;
    bit   model_on = 1'b1;
    int   nfall = 0;
    logic [7:0] rx_pat = 8'h00;
    logic [7:0] tx_cap = 8'h00;
    logic [7:0] v;

    sio_port #(.DIV(DIV)) i_sio_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .master(master), .sck_in(sck_in),
        .sck_out(sck_out), .sdi(sdi), .sdo(sdo)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: counts edges since the start write.
    int m_k = -1;
    bit m_spif = 0, m_dcol = 0, m_arm = 0, m_armsp = 0;
    always @(posedge clk) begin
        bit sacc, srd, coll, dn;
        int e;
        if (!rst_n) begin
            m_k = -1; m_spif = 0; m_dcol = 0; m_arm = 0; m_armsp = 0;
        end else begin
            sacc = (rd || wr) && addr == SDR;
            srd  = rd && addr == SSR;
            e    = (m_k >= 0) ? m_k + 1 : -1;
            coll = sacc && m_k >= HALF;
            dn   = (e == XE);
            if (sacc && m_arm)   m_spif = 0;
            if (sacc && m_armsp) m_dcol = 0;
            if (srd) begin m_armsp = m_spif; m_arm = 1; end
            else if (sacc) begin m_arm = 0; m_armsp = 0; end
            if (dn)   m_spif = 1;
            if (coll) m_dcol = 1;
            if (m_k < 0) begin
                if (wr && addr == SDR && master) m_k = 0;
            end else if (dn) m_k = -1;
            else m_k = e;
        end
    end

    // Compare against the model after every edge.
    always @(posedge clk) begin
        #5;
        if (rst_n && model_on) begin
            check("R2 sck level", sck_out, (m_k < 0) ? 1 : (((m_k / HALF) % 2 == 1) ? 0 : 1));
            if (addr == SSR) begin
                check("R4 model spif", rdata[7], m_spif);
                check("R7 model dcol", rdata[6], m_dcol);
            end
        end
    end

    // Remote slave for master transfers: drive input on falls, capture output on rises.
    always @(negedge sck_out) if (master && nfall < 8) begin
        sdi <= rx_pat[7 - nfall];
        nfall++;
    end
    always @(posedge sck_out) if (master) tx_cap <= {tx_cap[6:0], sdo};

    task automatic bus(input logic [7:0] a, input bit r, input bit w, input logic [7:0] d);
        @(negedge clk); addr = a; rd = r; wr = w; wdata = d;
        @(negedge clk); rd = 0; wr = 0; addr = SSR;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] val);
        @(negedge clk); addr = a; #1; val = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk) addr = SSR;
    endtask

    task automatic mstart(input logic [7:0] tx, input logic [7:0] rx);
        rx_pat = rx; nfall = 0; tx_cap = 0;
        bus(SDR, 0, 1, tx);
    endtask

    task automatic slave_xfer(input logic [7:0] rx, input int acc_at, output logic [7:0] mid);
        tx_cap = 0; mid = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sck_in = 0; sdi = rx[7 - i];
            repeat (HP) @(negedge clk);
            if (i == acc_at) begin bus(SDR, 1, 0, 0); peek(SSR, mid); end
            sck_in = 1; tx_cap = {tx_cap[6:0], sdo};
            repeat (HP) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] mid;
        repeat (3) @(negedge clk);
        peek(SSR, v); check("R1 reset status", v, 8'h00);
        check("R1 reset sck high", sck_out, 1);
        @(negedge clk); rst_n = 1;

        // R2/R3/R4: basic master transfer.
        mstart(8'hA5, 8'h3C); idle(XE + 4);
        check("R3 tx bits", tx_cap, 8'hA5);
        check("R2 fall count", nfall, 8);
        peek(SDR, v); check("R3 rx data", v, 8'h3C);
        peek(SSR, v); check("R4 spif set", v, 8'h80);

        // R5: wrong order, then correct order.
        bus(SDR, 1, 0, 0); bus(SSR, 1, 0, 0);
        peek(SSR, v); check("R5 wrong order keeps spif", v, 8'h80);
        bus(SDR, 1, 0, 0);
        peek(SSR, v); check("R5 clear sequence", v, 8'h00);

        // R6: clear by the starting write, set again at the end.
        mstart(8'h0F, 8'hF0); idle(XE + 4);
        bus(SSR, 1, 0, 0);
        mstart(8'h33, 8'h55); idle(10);
        peek(SSR, v); check("R6 cleared mid transfer", v, 8'h00);
        idle(XE);
        peek(SSR, v); check("R6 set again", v, 8'h80);
        peek(SDR, v); check("R3 rx second", v, 8'h55);
        check("R3 tx second", tx_cap, 8'h33);

        // R7/R10: write inside the window; timing of completion unchanged.
        bus(SSR, 1, 0, 0); bus(SDR, 1, 0, 0);
        mstart(8'h11, 8'h00);
        repeat (6) @(negedge clk);
        bus(SDR, 0, 1, 8'h22);
        peek(SSR, v); check("R7 collision on write", v, 8'h40);
        repeat (21) @(negedge clk);
        peek(SSR, v); check("R10 not done one clock early", v, 8'h40);
        peek(SSR, v); check("R10 done at original time", v, 8'hC0);

        // R8: handshake for the collision flag.
        bus(SSR, 1, 0, 0); bus(SDR, 1, 0, 0);
        peek(SSR, v); check("R8 both cleared", v, 8'h00);
        mstart(8'h44, 8'h00); idle(10);
        bus(SDR, 1, 0, 0);
        bus(SSR, 1, 0, 0);
        idle(XE);
        peek(SSR, v); check("R7 collision on read", v, 8'hC0);
        bus(SDR, 1, 0, 0);
        peek(SSR, v); check("R8 dcol kept when armed without spif", v, 8'h40);
        mstart(8'h66, 8'h99); idle(XE + 4);
        bus(SSR, 1, 0, 0); bus(SDR, 1, 0, 0);
        peek(SSR, v); check("R8 dcol cleared", v, 8'h00);

        // R11/R12: slave mode, reset keeps data.
        model_on = 0;
        @(negedge clk); master = 0;
        bus(SDR, 0, 1, 8'h7E); idle(6);
        check("R12 no clock from write", sck_out, 1);
        peek(SSR, v); check("R12 no transfer from write", v, 8'h00);
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        peek(SDR, v); check("R11 data kept over reset", v, 8'h7E);
        peek(SSR, v); check("R1 flags after reset", v, 8'h00);

        bus(SDR, 0, 1, 8'hC3);
        slave_xfer(8'h96, 3, mid);
        check("R12 slave tx bits", tx_cap, 8'hC3);
        peek(SDR, v); check("R12 slave rx data", v, 8'h96);
        peek(SSR, v); check("R7 slave collision and done", v, 8'hC0);

        // R9: clearing access overlapping a new transfer.
        bus(SSR, 1, 0, 0);
        slave_xfer(8'h5A, 0, mid);
        check("R9 dcol set again on overlap", mid, 8'h40);
        peek(SSR, v); check("R9 flags at end", v, 8'hC0);
        peek(SDR, v); check("R12 slave rx second", v, 8'h5A);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule